// File: doc/BRIEF.md
# Down-Counting Event Timer with Interrupt

This block is a single one-shot countdown timer on a small register window, meant to wake a processor after a chosen number of clock ticks. Software first switches the timer on through its control word, then writes a tick count to the value register. That write loads the counter and starts the countdown at once. When the count runs out, a sticky pending flag is set. The interrupt line is that flag gated by an interrupt-enable bit. The flag is cleared by writing a control word with the clear bit set.

The timer is built around a four-state machine:
- `ST_OFF`: timer switched off.
- `ST_IDLE`: switched on, no countdown.
- `ST_RUN`: counting down.
- `ST_DONE`: expired, counter parked at zero.

The transitions are:
- *power-on*: `ST_OFF` to `ST_IDLE`, taken on a control write with bit 0 set.
- *start*: `ST_IDLE` to `ST_RUN`, taken on a value write.
- *expire*: `ST_RUN` to `ST_DONE`, taken when the count is 1 or 0.
- *restart*: `ST_RUN` or `ST_DONE` to `ST_RUN`, taken on a value write.
- *shutdown*: any state to `ST_OFF`, taken on a control write with bit 0 clear.

Interrupt enable and clear are held beside the machine. The interrupt output is gated combinationally from them.

Top module: `evt_timer`

## Requirements
- R1: After reset the timer is in `ST_OFF`, the count is 0, interrupt enable and pending are 0, and `irq_o` is 0.
- R2: The control register is at offset 0x40. Bit 0 is the timer enable, bit 1 is the interrupt enable and bit 4 is the clear. A read returns the enable in bit 0 and the interrupt enable in bit 1. Bit 4 and all other bits read 0.
- R3: A write to the value register at offset 0x44 while the timer is enabled loads the count from the write data on that clock edge and enters `ST_RUN`. A read of offset 0x44 returns the current count.
- R4: In `ST_RUN` the count drops by one per clock. On the edge where the count is 1 or 0, the count becomes 0, the pending flag is set and the state becomes `ST_DONE`. A load of N ≥ 1 therefore sets pending N edges after the load edge.
- R5: `irq_o` equals pending AND interrupt enable. Pending is sticky while the interrupt enable is 0.
- R6: A control write with bits 0 and 4 set clears pending. Every control write loads the interrupt enable from bit 1 ANDed with bit 0, so writing 0x11 clears the flag and disables the interrupt.
- R7: While the timer is off, value writes are ignored. A control write whose bit 0 is 0 cannot set the interrupt enable or clear pending.
- R8: A control write with bit 0 clear enters `ST_OFF` and clears the interrupt enable. It keeps the count and the pending flag. A later write with bit 0 set enters `ST_IDLE` with the count still held.
- R9: A value write in `ST_RUN` or `ST_DONE` reloads the count and restarts the countdown.
- R10: On one edge, shutdown beats load and load beats expiry. An expiry that sets pending beats a clear on the same edge.
- R11: Writes to offsets other than 0x40 and 0x44 change nothing, and reads of those offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset within the timer window |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from `bus_addr` |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The assertions assume the following about the bus:
- Each access is one clock wide.
- At most one register is written per edge.
- Address and data are stable around the rising edge.

The bench drives every access on the falling edge and holds it for a full cycle. Its collision cases (clear, shutdown or reload landing on the expiry edge) are placed by counting edges from the load, so each priority rule is reached on purpose rather than by chance.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_IDLE = 2'd1,
        ST_RUN  = 2'd2,
        ST_DONE = 2'd3
    } tmr_state_e;

    localparam int CTL_EN_BIT  = 0;
    localparam int CTL_IE_BIT  = 1;
    localparam int CTL_CLR_BIT = 4;
endpackage

// File: rtl/evt_timer_decode.sv
module evt_timer_decode
    import evt_timer_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] CTL_OFS = 'h40,
    parameter logic [ADDR_W-1:0] VAL_OFS = 'h44
) (
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              ctl_wr,
    output logic              val_wr,
    output logic              en_set,
    output logic              en_stop,
    output logic              clr_req,
    output logic              ie_val
);
    logic wr;

    always_comb begin
        wr      = bus_valid && bus_write;
        ctl_wr  = wr && (bus_addr == CTL_OFS);
        val_wr  = wr && (bus_addr == VAL_OFS);
        en_set  = ctl_wr &&  bus_wdata[CTL_EN_BIT];
        en_stop = ctl_wr && !bus_wdata[CTL_EN_BIT];
        clr_req = en_set && bus_wdata[CTL_CLR_BIT];
        ie_val  = bus_wdata[CTL_EN_BIT] && bus_wdata[CTL_IE_BIT];
    end
endmodule

// File: rtl/evt_timer_fsm.sv
module evt_timer_fsm
    import evt_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_set,
    input  logic             en_stop,
    input  logic             val_wr,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             clr_req,
    output tmr_state_e       state_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             pend_o,
    output logic             enabled_o
);
    tmr_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic             pend_q;
    logic             load, expire, at_end;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OFF:  if (en_set) st_d = ST_IDLE;
            ST_IDLE: if (en_stop) st_d = ST_OFF;
                     else if (val_wr) st_d = ST_RUN;
            ST_RUN:  if (en_stop) st_d = ST_OFF;
                     else if (val_wr) st_d = ST_RUN;
                     else if (at_end) st_d = ST_DONE;
            ST_DONE: if (en_stop) st_d = ST_OFF;
                     else if (val_wr) st_d = ST_RUN;
            default: st_d = ST_OFF;
        endcase
    end

    // outputs and strobes
    always_comb begin
        at_end    = (cnt_q <= CNT_W'(1));
        enabled_o = (st_q != ST_OFF);
        load      = val_wr && enabled_o && !en_stop;
        expire    = (st_q == ST_RUN) && at_end && !en_stop && !val_wr;
        state_o   = st_q;
        cnt_o     = cnt_q;
        pend_o    = pend_q;
    end

    // counter and pending flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (load)
                cnt_q <= ld_val;
            else if ((st_q == ST_RUN) && !en_stop)
                cnt_q <= at_end ? '0 : cnt_q - CNT_W'(1);
            if (expire)
                pend_q <= 1'b1;
            else if (clr_req)
                pend_q <= 1'b0;
        end
    end
endmodule

// File: rtl/evt_timer_irq.sv
module evt_timer_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic ie_val,
    input  logic pend,
    output logic ie_o,
    output logic irq_o
);
    logic ie_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ie_q <= 1'b0;
        else if (ctl_wr) ie_q <= ie_val;
    end

    always_comb begin
        ie_o  = ie_q;
        irq_o = ie_q && pend;
    end
endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] CTL_OFS = 'h40,
    parameter logic [ADDR_W-1:0] VAL_OFS = 'h44
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    logic              ctl_wr, val_wr, en_set, en_stop, clr_req, ie_val;
    tmr_state_e        st_w;
    logic [DATA_W-1:0] cnt_w;
    logic              pend_w, en_w, ie_w;

    evt_timer_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTL_OFS(CTL_OFS), .VAL_OFS(VAL_OFS)
    ) u_dec (
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .ctl_wr(ctl_wr), .val_wr(val_wr),
        .en_set(en_set), .en_stop(en_stop), .clr_req(clr_req), .ie_val(ie_val)
    );

    evt_timer_fsm #(.CNT_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en_set(en_set), .en_stop(en_stop),
        .val_wr(val_wr), .ld_val(bus_wdata), .clr_req(clr_req),
        .state_o(st_w), .cnt_o(cnt_w), .pend_o(pend_w), .enabled_o(en_w)
    );

    evt_timer_irq u_irq (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ie_val(ie_val),
        .pend(pend_w), .ie_o(ie_w), .irq_o(irq_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CTL_OFS) begin
            bus_rdata[CTL_EN_BIT] = en_w;
            bus_rdata[CTL_IE_BIT] = ie_w;
        end else if (bus_addr == VAL_OFS) begin
            bus_rdata = cnt_w;
        end
    end
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk
    import evt_timer_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] CTL_OFS = 'h40,
    parameter logic [ADDR_W-1:0] VAL_OFS = 'h44
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq_o,
    input tmr_state_e        st,
    input logic [DATA_W-1:0] cnt,
    input logic              pend,
    input logic              ie
);
    logic any_wr, c_wr, v_wr;
    assign any_wr = bus_valid && bus_write;
    assign c_wr   = any_wr && (bus_addr == CTL_OFS);
    assign v_wr   = any_wr && (bus_addr == VAL_OFS);

    AST_LOAD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (v_wr && st != ST_OFF) |=> (cnt == $past(bus_wdata) && st == ST_RUN)); // R3
    AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_OFF && !c_wr) |=> ($stable(cnt) && st == ST_OFF)); // R7
    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && !any_wr && cnt > 1) |=> (cnt == $past(cnt) - 1)); // R4
    AST_EXPIRE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && !any_wr && cnt <= 1) |=> (pend && cnt == 0 && st == ST_DONE)); // R4
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pend && ie)); // R5
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (c_wr && bus_wdata[CTL_EN_BIT] && bus_wdata[CTL_CLR_BIT] && st != ST_RUN) |=> !pend); // R6
    AST_STOP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (c_wr && !bus_wdata[CTL_EN_BIT]) |=> (st == ST_OFF && !ie && $stable(cnt))); // R8
endmodule

bind evt_timer evt_timer_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTL_OFS(CTL_OFS), .VAL_OFS(VAL_OFS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq_o(irq_o),
    .st(st_w), .cnt(cnt_w), .pend(pend_w), .ie(ie_w)
);

// File: tb/evt_timer_tb_top.sv
`timescale 1ns/1ps
module evt_timer_tb_top;
    localparam logic [7:0] A_CTL = 8'h40;
    localparam logic [7:0] A_VAL = 8'h44;
    localparam logic [7:0] A_BAD = 8'h48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = 8'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    always #2.5 clk = ~clk;

    evt_timer dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    finished = 0;
    string cur_req = "R1";

    // behavioural reference: 0 off, 1 idle, 2 run, 3 done
    int          m_st = 0;
    logic [31:0] m_cnt = 0;
    bit          m_ie = 0, m_pend = 0;

    function automatic logic [31:0] exp_rdata(logic [7:0] a);
        if (a == A_CTL) return {30'd0, m_ie, (m_st != 0)};
        if (a == A_VAL) return m_cnt;
        return 32'd0;
    endfunction

    task automatic compare();
        logic [31:0] er;
        er = exp_rdata(bus_addr);
        n_tests++;
        if (bus_rdata !== er || irq_o !== (m_pend && m_ie)) begin
            n_fail++;
            $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                     cur_req, bus_rdata, irq_o, er, (m_pend && m_ie));
        end
    endtask

    task automatic model_edge(bit v, bit w, logic [7:0] a, logic [31:0] d);
        bit cw, vw, expd;
        cw = v && w && (a == A_CTL);
        vw = v && w && (a == A_VAL);
        expd = 0;
        if (cw) m_ie = d[0] && d[1];
        if (cw && !d[0]) m_st = 0;
        else if (vw && m_st != 0) begin m_cnt = d; m_st = 2; end
        else if (m_st == 2) begin
            if (m_cnt <= 1) begin m_cnt = 0; m_st = 3; expd = 1; end
            else m_cnt = m_cnt - 1;
        end else if (cw && d[0] && m_st == 0) m_st = 1;
        if (expd) m_pend = 1;
        else if (cw && d[0] && d[4]) m_pend = 0;
    endtask

    task automatic step(bit v, bit w, logic [7:0] a, logic [31:0] d);
        bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d;
        #1;
        compare();
        @(posedge clk);
        model_edge(v, w, a, d);
        @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d); step(1, 1, a, d); endtask
    task automatic rd(logic [7:0] a, int n);
        for (int i = 0; i < n; i++) step(1, 0, a, 32'd0);
    endtask

    initial begin
        #(5.0 * 20000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        cur_req = "R1"; rd(A_CTL, 1); rd(A_VAL, 1);
        rst_n = 1'b1;
        rd(A_CTL, 1); rd(A_VAL, 1);

        cur_req = "R7";                 // writes while off are ignored
        wr(A_VAL, 32'd10); rd(A_VAL, 1);
        wr(A_CTL, 32'h12); rd(A_CTL, 1);

        cur_req = "R2";                 // enable, ie, clear; bit4 reads 0
        wr(A_CTL, 32'h13); rd(A_CTL, 2);

        cur_req = "R3";                 // load 5 and watch countdown
        wr(A_VAL, 32'd5);
        cur_req = "R4"; rd(A_VAL, 7);
        cur_req = "R5"; rd(A_CTL, 2);

        cur_req = "R6";                 // clear plus ie off
        wr(A_CTL, 32'h11); rd(A_CTL, 1);
        cur_req = "R5";                 // pending sticky with ie off
        wr(A_VAL, 32'd3); rd(A_VAL, 5);
        wr(A_CTL, 32'h03); rd(A_VAL, 2);
        cur_req = "R6";
        wr(A_CTL, 32'h13); rd(A_CTL, 2);

        cur_req = "R9";                 // reload while running and after done
        wr(A_VAL, 32'd20); rd(A_VAL, 4);
        wr(A_VAL, 32'd4);  rd(A_VAL, 6);
        wr(A_VAL, 32'd3);  rd(A_VAL, 5);

        cur_req = "R8";                 // shutdown holds count and pending
        wr(A_CTL, 32'h13);
        wr(A_VAL, 32'd10); rd(A_VAL, 3);
        wr(A_CTL, 32'h00); rd(A_VAL, 3); rd(A_CTL, 1);
        cur_req = "R7";
        wr(A_VAL, 32'd7); rd(A_VAL, 1);
        cur_req = "R8";
        wr(A_CTL, 32'h01); rd(A_VAL, 3);
        wr(A_VAL, 32'd3);  rd(A_VAL, 4);

        cur_req = "R10";                // clear on expiry edge: expiry wins
        wr(A_CTL, 32'h13);
        wr(A_VAL, 32'd2); rd(A_VAL, 1); wr(A_CTL, 32'h13); rd(A_CTL, 2);
        wr(A_CTL, 32'h13);              // stop on expiry edge: no pending
        wr(A_VAL, 32'd2); rd(A_VAL, 1); wr(A_CTL, 32'h00); rd(A_VAL, 2);
        wr(A_CTL, 32'h03);              // load on expiry edge: reload wins
        wr(A_VAL, 32'd2); rd(A_VAL, 1); wr(A_VAL, 32'd6); rd(A_VAL, 8);
        cur_req = "R4";                 // zero load expires on next edge
        wr(A_CTL, 32'h13); wr(A_VAL, 32'd0); rd(A_VAL, 2);

        cur_req = "R11";                // unmapped offset
        wr(A_CTL, 32'h13); wr(A_VAL, 32'd9); wr(A_BAD, 32'hFFFF_FFFF);
        rd(A_BAD, 1); rd(A_VAL, 2); rd(A_CTL, 1);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule